// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block generates the column address for each beat of a synchronous DRAM burst. A controller pulses `start` along with a starting column, a burst length code and a burst order flag. From the next clock on, the block presents one column per cycle on `col_out` with `col_valid` high. It raises `last_beat` on the final beat of a fixed-length burst.

Fixed-length bursts stay inside the naturally aligned window of their length. In linear order, the low window bits count up from the start column and wrap with no carry into higher bits. In interleaved order, beat k uses the start column with its window bits exclusive-ORed with k. In page mode the whole column space is walked, wrapping at the page end. A page-mode burst runs until `stop` is pulsed. A stop request in any other situation is reported as illegal and has no effect.

A new `start` may arrive at any time, including during a burst. It drops whatever remains of the old burst and begins a complete new one.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the block goes idle. In the next cycle `col_valid`, `last_beat` and `stop_illegal` are 0, even if a burst was running.
- R2: When `start` is sampled high, `col_valid` is 1 in the following cycle and `col_out` equals the sampled `start_col`.
- R3: `bl_code` selects the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and every other code except 3'b111 gives 1. `last_beat` is 1 exactly on the final beat, and `col_valid` is 0 in the cycle after it unless a new start was sampled.
- R4: With `burst_il`=0 and a fixed length L, beat k has its low log2(L) bits equal to (start + k) mod L. All higher bits equal those of the start column.
- R5: With `burst_il`=1 and a fixed length L, beat k has its low log2(L) bits equal to the start column's low bits XOR k. All higher bits are unchanged.
- R6: `bl_code`=3'b111 selects page mode. Beat k is (start + k) mod 2^COL_W for linear order and start XOR (k mod 2^COL_W) for interleaved order. The burst continues past the page end, and `last_beat` stays 0.
- R7: A `stop` sampled during a page-mode burst, with no `start` in the same cycle, makes `col_valid` 0 in the next cycle.
- R8: A `stop` sampled while no page-mode burst runs sets `stop_illegal` to 1 for the next cycle. The running burst then continues its remaining beats unchanged.
- R9: A `start` sampled during a burst drops the remaining beats. The next cycle shows the new start column, followed by the full new length.
- R10: `bl_code` and `burst_il` are sampled only with `start`. Changing them during a burst does not alter that burst's addresses or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new burst |
| start_col | input | COL_W | First column of the burst |
| bl_code | input | 3 | Burst length code |
| burst_il | input | 1 | 1 selects interleaved order, 0 linear order |
| stop | input | 1 | End a page-mode burst |
| col_out | output | COL_W | Column of the current beat (0 when idle) |
| col_valid | output | 1 | A beat is being presented |
| last_beat | output | 1 | Final beat of a fixed-length burst |
| stop_illegal | output | 1 | Stop was requested outside page mode |

## Verification
Every result is due exactly one rising edge after the stimulus that causes it. The first beat appears the cycle after `start`, the next cycle of `last_beat` shows `col_valid` low, and both the idle state after a page-mode stop and the `stop_illegal` pulse follow their request by one cycle. The bench changes inputs and samples outputs on the falling edge. One falling edge therefore separates a stimulus from its result, and each later beat is compared on each later falling edge against a model computed from R3–R6.

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             burst_il,
  input  logic             stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             last_beat,
  output logic             stop_illegal
);

  logic             act_q, page_q, il_q, bad_q;
  logic [COL_W-1:0] base_q, win_q, beat_q;
  logic [COL_W-1:0] win_d, lin_sum, step_bits;
  logic             at_end;

  always_comb begin
    case (bl_code)
      3'b001:  win_d = COL_W'(1);
      3'b010:  win_d = COL_W'(3);
      3'b011:  win_d = COL_W'(7);
      3'b111:  win_d = '1;
      default: win_d = '0;
    endcase
  end

  assign lin_sum   = base_q + beat_q;
  assign step_bits = il_q ? (base_q ^ beat_q) : lin_sum;
  assign at_end    = !page_q && (beat_q == win_q);

  assign col_valid    = act_q;
  assign col_out      = act_q ? ((base_q & ~win_q) | (step_bits & win_q)) : '0;
  assign last_beat    = act_q && at_end;
  assign stop_illegal = bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      page_q <= 1'b0;
      il_q   <= 1'b0;
      bad_q  <= 1'b0;
      base_q <= '0;
      win_q  <= '0;
      beat_q <= '0;
    end else begin
      bad_q <= stop && !(act_q && page_q);
      if (start) begin
        act_q  <= 1'b1;
        page_q <= (bl_code == 3'b111);
        il_q   <= burst_il;
        base_q <= start_col;
        win_q  <= win_d;
        beat_q <= '0;
      end else if (act_q && page_q && stop) begin
        act_q <= 1'b0;
      end else if (act_q) begin
        if (at_end) act_q  <= 1'b0;
        else        beat_q <= beat_q + COL_W'(1);
      end
    end
  end

endmodule

module sdram_col_burst_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [COL_W-1:0] start_col,
  input logic             stop,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             last_beat,
  input logic             stop_illegal
);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!col_valid && !last_beat && !stop_illegal));

  p_first_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (col_valid && col_out == $past(start_col)));

  p_last_is_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid);

  p_end_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !start) |=> !col_valid);

  p_beats_differ_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && !start && !stop && !last_beat) |=> (col_valid && col_out != $past(col_out)));

  p_flag_needs_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop) |=> !stop_illegal);

endmodule

bind sdram_col_burst_gen sdram_col_burst_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col), .stop(stop),
  .col_out(col_out), .col_valid(col_valid), .last_beat(last_beat),
  .stop_illegal(stop_illegal)
);

// File: tb/tb_sdram_col_burst_gen.sv
module tb_sdram_col_burst_gen;
  localparam int COL_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0]       bl_code = '0;
  logic             burst_il = 1'b0;
  logic             stop = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid, last_beat, stop_illegal;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  sdram_col_burst_gen #(.COL_W(COL_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_col(start_col),
    .bl_code(bl_code), .burst_il(burst_il), .stop(stop), .col_out(col_out),
    .col_valid(col_valid), .last_beat(last_beat), .stop_illegal(stop_illegal)
  );

  task automatic chk(input string req, input int actual, input int expected);
    n_chk++;
    if (actual != expected) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  function automatic int beats_of(input logic [2:0] code);
    case (code)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] b, input logic [2:0] code,
                                         input logic il, input int k);
    logic [7:0] w, kk, s;
    w  = (code == 3'b111) ? 8'hFF : 8'(beats_of(code) - 1);
    kk = 8'(k);
    s  = il ? (b ^ kk) : (b + kk);
    return (b & ~w) | (s & w);
  endfunction

  task automatic kick(input logic [7:0] c, input logic [2:0] code, input logic il);
    start = 1'b1; start_col = c; bl_code = code; burst_il = il;
    @(negedge clk);
    start = 1'b0; start_col = ~c; bl_code = ~code; burst_il = ~il;
  endtask

  task automatic run_burst(input string req, input logic [7:0] c,
                           input logic [2:0] code, input logic il);
    int n;
    n = beats_of(code);
    kick(c, code, il);
    for (int i = 0; i < n; i++) begin
      chk({req, " valid"}, int'(col_valid), 1);
      chk({req, " col"}, int'(col_out), int'(exp_col(c, code, il, i)));
      chk({req, " last"}, int'(last_beat), (i == n - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk({req, " R3 idle after last"}, int'(col_valid), 0);
  endtask

  task automatic t_reset();
    chk("R1 valid at reset", int'(col_valid), 0);
    chk("R1 last at reset", int'(last_beat), 0);
    chk("R1 flag at reset", int'(stop_illegal), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_linear();
    run_burst("R2 R4 lin bl4", 8'h2E, 3'b010, 1'b0);
    run_burst("R4 lin bl8", 8'h45, 3'b011, 1'b0);
    run_burst("R4 lin bl2", 8'h11, 3'b001, 1'b0);
    run_burst("R3 bl1", 8'h5A, 3'b000, 1'b0);
    run_burst("R3 code101 as 1", 8'h77, 3'b101, 1'b0);
  endtask

  task automatic t_interleave();
    run_burst("R5 il bl8", 8'h93, 3'b011, 1'b1);
    run_burst("R5 il bl4", 8'hC6, 3'b010, 1'b1);
    run_burst("R5 il bl2", 8'h0F, 3'b001, 1'b1);
  endtask

  task automatic t_page(input logic il);
    kick(8'hF0, 3'b111, il);
    for (int i = 0; i < 260; i++) begin
      chk("R6 page valid", int'(col_valid), 1);
      chk("R6 page col", int'(col_out), int'(exp_col(8'hF0, 3'b111, il, i)));
      chk("R6 page no last", int'(last_beat), 0);
      @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R7 stop ends page", int'(col_valid), 0);
    chk("R7 legal stop not flagged", int'(stop_illegal), 0);
    @(negedge clk);
  endtask

  task automatic t_bad_stop();
    kick(8'h45, 3'b011, 1'b0);
    for (int i = 0; i < 8; i++) begin
      chk("R8 valid", int'(col_valid), 1);
      chk("R8 col", int'(col_out), int'(exp_col(8'h45, 3'b011, 1'b0, i)));
      chk("R8 flag", int'(stop_illegal), (i == 3) ? 1 : 0);
      stop = (i == 2);
      @(negedge clk);
    end
    stop = 1'b0;
    chk("R8 ended normally", int'(col_valid), 0);
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    chk("R8 idle stop flagged", int'(stop_illegal), 1);
    chk("R8 idle stop no burst", int'(col_valid), 0);
    @(negedge clk);
    chk("R8 flag one cycle", int'(stop_illegal), 0);
  endtask

  task automatic t_restart();
    kick(8'h20, 3'b011, 1'b1);
    for (int i = 0; i < 3; i++) begin
      chk("R9 old col", int'(col_out), int'(exp_col(8'h20, 3'b011, 1'b1, i)));
      if (i < 2) @(negedge clk);
    end
    kick(8'h5A, 3'b010, 1'b0);
    for (int i = 0; i < 4; i++) begin
      chk("R9 new valid", int'(col_valid), 1);
      chk("R9 new col", int'(col_out), int'(exp_col(8'h5A, 3'b010, 1'b0, i)));
      chk("R9 new last", int'(last_beat), (i == 3) ? 1 : 0);
      @(negedge clk);
    end
    chk("R9 new burst ends", int'(col_valid), 0);
  endtask

  task automatic t_sampled_once();
    kick(8'h31, 3'b001, 1'b0);
    bl_code = 3'b111; burst_il = 1'b1;
    chk("R10 beat0", int'(col_out), 8'h31);
    @(negedge clk);
    chk("R10 beat1", int'(col_out), 8'h30);
    chk("R10 last kept", int'(last_beat), 1);
    @(negedge clk);
    chk("R10 length kept", int'(col_valid), 0);
  endtask

  task automatic t_reset_mid();
    kick(8'h80, 3'b111, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid burst", int'(col_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stays idle", int'(col_valid), 0);
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    t_linear();
    t_interleave();
    t_page(1'b0);
    t_page(1'b1);
    t_bad_stop();
    t_restart();
    t_sampled_once();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule